// File: doc/BRIEF.md
# Page Cache Write-Back Controller

This block stands between a serial byte-write path and a nonvolatile array whose write unit is a page of 8 bytes. It holds a cache of eight such pages (64 bytes in all), so a burst of bytes can be taken at bus speed and committed to the array later, one page at a time. The first byte loaded into an empty cache fixes the base array page. Every later byte lands in the cache page given by its distance from that base, and a byte whose page lies more than seven pages past the base is dropped.

A commit request, raised by the protocol layer at the end of a write transfer, starts the write-back. Only cache pages that received at least one byte are sent. Cache page `i` goes to array page `base + i`, wrapping past the top of the array. Each page transfer is followed by its own self-timed write delay before the next page is sent. A busy flag covers the whole write-back, and loads and commits are refused while it is high. When the last page has finished, the cache is emptied and the next load sets a new base.

Top module: `pcw_cache_ctrl`

## Requirements
- R1: After reset, `busy` and `arr_start` are low and the cache is empty.
- R2: When `busy` is low, a load stores `ld_data` in byte `ld_addr[2:0]` of the cache page for array page `ld_addr[ADDR_W-1:3]`. A later load to the same byte replaces the earlier value.
- R3: The first accepted load into an empty cache sets the base array page. A load whose page offset from the base, modulo `ARRAY_PAGES`, is `CACHE_PAGES` or more is ignored.
- R4: A commit with at least one loaded page raises `busy` in the next cycle. A commit into an empty cache is ignored and `busy` stays low.
- R5: Loaded pages are written back in ascending cache-page order. Cache page `i` goes to `arr_row = (base + i) mod ARRAY_PAGES`, so the row wraps to 0 past the top.
- R6: Only pages holding at least one loaded byte produce a write. `arr_mask` bit `b` is set exactly for the loaded bytes. `arr_data[8b+7:8b]` carries byte `b`, and bytes that were not loaded read as 0.
- R7: `arr_start` is a one-cycle pulse. Consecutive page starts of one write-back are exactly `WRITE_CYCLES + 1` cycles apart.
- R8: `busy` falls `WRITE_CYCLES + 1` cycles after the last page start. The cache is then empty, so the next load sets a new base.
- R9: While `busy` is high, loads change neither the cache contents nor the data written, and commit requests start nothing extra.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Byte load strobe |
| ld_addr | input | ADDR_W | Byte address: array page in the upper bits, byte within the page in the low 3 bits |
| ld_data | input | 8 | Byte to load |
| commit | input | 1 | Request to write the cache back |
| busy | output | 1 | High from the cycle after an accepted commit until the last page delay ends |
| arr_start | output | 1 | One-cycle pulse that starts an array page write |
| arr_row | output | ROW_W | Array page address for the write |
| arr_data | output | 8*PAGE_BYTES | Page data, byte `b` in bits `[8b+7:8b]` |
| arr_mask | output | PAGE_BYTES | Per-byte flag: set for bytes that were loaded |

## Verification
The bench builds the block with `ARRAY_PAGES = 16` and `WRITE_CYCLES = 5`. With 16 array pages, a base near the top wraps to row 0 inside one write-back. With a 5-cycle delay, the exact spacing between page starts and the fall of `busy` can be checked cycle by cycle within a short run. Page size and cache depth keep their default values of 8, so a full-window burst, a skipped page and out-of-window loads on both sides of the base can all be exercised.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SCAN,
        SEQ_WAIT
    } seq_state_e;

endpackage

// File: rtl/pcw_store.sv
module pcw_store #(
    parameter int PAGE_BYTES  = 8,
    parameter int CACHE_PAGES = 8,
    parameter int ROW_W       = 10,
    localparam int BYTE_W     = $clog2(PAGE_BYTES),
    localparam int PIDX_W     = $clog2(CACHE_PAGES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_valid_i,
    input  logic [ROW_W-1:0]        ld_row_i,
    input  logic [BYTE_W-1:0]       ld_byte_i,
    input  logic [7:0]              ld_data_i,
    input  logic                    busy_i,
    input  logic                    clr_i,
    input  logic [PIDX_W-1:0]       rd_page_i,
    output logic [ROW_W-1:0]        base_row_o,
    output logic [CACHE_PAGES-1:0]  valid_o,
    output logic [PAGE_BYTES*8-1:0] rd_data_o,
    output logic [PAGE_BYTES-1:0]   rd_mask_o
);

    localparam logic [ROW_W:0] WINDOW = (ROW_W+1)'(CACHE_PAGES);

    typedef struct packed {
        logic [CACHE_PAGES-1:0][PAGE_BYTES-1:0][7:0] data;
        logic [CACHE_PAGES-1:0][PAGE_BYTES-1:0]      bmask;
        logic [ROW_W-1:0]                            base;
    } store_t;

    store_t s_d, s_q;

    logic             any_valid;
    logic [ROW_W-1:0] eff_base;
    logic [ROW_W-1:0] offset;
    logic             accept;

    genvar gp;
    generate
        for (gp = 0; gp < CACHE_PAGES; gp++) begin : g_valid
            assign valid_o[gp] = |s_q.bmask[gp];
        end
    endgenerate

    assign any_valid = |valid_o;

    always_comb begin
        s_d      = s_q;
        eff_base = any_valid ? s_q.base : ld_row_i;
        offset   = ld_row_i - eff_base;
        accept   = ld_valid_i && !busy_i && ({1'b0, offset} < WINDOW);
        if (accept) begin
            s_d.base = eff_base;
            s_d.data[offset[PIDX_W-1:0]][ld_byte_i]  = ld_data_i;
            s_d.bmask[offset[PIDX_W-1:0]][ld_byte_i] = 1'b1;
        end
        if (clr_i) begin
            s_d.data  = '0;
            s_d.bmask = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign base_row_o = s_q.base;
    assign rd_data_o  = s_q.data[rd_page_i];
    assign rd_mask_o  = s_q.bmask[rd_page_i];

    AST_BUSY_FREEZES_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !clr_i) |=> $stable(valid_o) && $stable(s_q.data)); // R9

    AST_FIRST_LOAD_SETS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_valid && ld_valid_i && !busy_i) |=> (base_row_o == $past(ld_row_i))); // R3

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (valid_o == '0)); // R8

endmodule

// File: rtl/pcw_seq.sv
module pcw_seq
    import pcw_pkg::*;
#(
    parameter int PAGE_BYTES   = 8,
    parameter int CACHE_PAGES  = 8,
    parameter int ROW_W        = 10,
    parameter int WRITE_CYCLES = 20000,
    localparam int PIDX_W      = $clog2(CACHE_PAGES),
    localparam int IDX_W       = PIDX_W + 1,
    localparam int TMR_W       = (WRITE_CYCLES > 2) ? $clog2(WRITE_CYCLES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic [CACHE_PAGES-1:0]  valid_i,
    input  logic [ROW_W-1:0]        base_row_i,
    input  logic [PAGE_BYTES*8-1:0] rd_data_i,
    input  logic [PAGE_BYTES-1:0]   rd_mask_i,
    output logic [PIDX_W-1:0]       rd_page_o,
    output logic                    clr_o,
    output logic                    busy_o,
    output logic                    start_o,
    output logic [ROW_W-1:0]        row_o,
    output logic [PAGE_BYTES*8-1:0] data_o,
    output logic [PAGE_BYTES-1:0]   mask_o
);

    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(WRITE_CYCLES - 1);

    typedef struct packed {
        seq_state_e              state;
        logic [IDX_W-1:0]        idx;
        logic [TMR_W-1:0]        timer;
        logic                    start;
        logic [ROW_W-1:0]        row;
        logic [PAGE_BYTES*8-1:0] data;
        logic [PAGE_BYTES-1:0]   mask;
    } seq_t;

    seq_t s_d, s_q;

    logic [CACHE_PAGES-1:0] pending;
    logic                   found;
    logic [PIDX_W-1:0]      pick;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < CACHE_PAGES; i++) begin
            pending[i] = valid_i[i] && (IDX_W'(i) >= s_q.idx);
        end
        for (int i = CACHE_PAGES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                pick  = PIDX_W'(i);
                found = 1'b1;
            end
        end
    end

    assign rd_page_o = pick;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        clr_o     = 1'b0;
        unique case (s_q.state)
            SEQ_IDLE: begin
                if (commit_i && (|valid_i)) begin
                    s_d.state = SEQ_SCAN;
                    s_d.idx   = '0;
                end
            end
            SEQ_SCAN: begin
                if (found) begin
                    s_d.state = SEQ_WAIT;
                    s_d.start = 1'b1;
                    s_d.row   = base_row_i + ROW_W'(pick);
                    s_d.data  = rd_data_i;
                    s_d.mask  = rd_mask_i;
                    s_d.timer = TMR_LOAD;
                    s_d.idx   = IDX_W'(pick) + IDX_W'(1);
                end else begin
                    clr_o     = 1'b1;
                    s_d.state = SEQ_IDLE;
                end
            end
            SEQ_WAIT: begin
                if (s_q.timer == '0) begin
                    s_d.state = SEQ_SCAN;
                end else begin
                    s_d.timer = s_q.timer - TMR_W'(1);
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: SEQ_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o  = (s_q.state != SEQ_IDLE);
    assign start_o = s_q.start;
    assign row_o   = s_q.row;
    assign data_o  = s_q.data;
    assign mask_o  = s_q.mask;

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o); // R7

    AST_START_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (mask_o != '0)); // R6

    AST_START_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_o); // R4

    AST_EMPTY_COMMIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && commit_i && (valid_i == '0)) |=> !busy_o); // R4

    AST_COMMIT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && commit_i && (valid_i != '0)) |=> busy_o); // R4

endmodule

// File: rtl/pcw_cache_ctrl.sv
module pcw_cache_ctrl #(
    parameter int PAGE_BYTES   = 8,
    parameter int CACHE_PAGES  = 8,
    parameter int ARRAY_PAGES  = 1024,
    parameter int WRITE_CYCLES = 20000,
    localparam int ROW_W       = $clog2(ARRAY_PAGES),
    localparam int BYTE_W      = $clog2(PAGE_BYTES),
    localparam int ADDR_W      = ROW_W + BYTE_W,
    localparam int PIDX_W      = $clog2(CACHE_PAGES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_valid,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic [7:0]              ld_data,
    input  logic                    commit,
    output logic                    busy,
    output logic                    arr_start,
    output logic [ROW_W-1:0]        arr_row,
    output logic [PAGE_BYTES*8-1:0] arr_data,
    output logic [PAGE_BYTES-1:0]   arr_mask
);

    localparam logic [ROW_W:0] WINDOW = (ROW_W+1)'(CACHE_PAGES);

    logic [ROW_W-1:0]        base_row;
    logic [CACHE_PAGES-1:0]  page_valid;
    logic [PAGE_BYTES*8-1:0] rd_data;
    logic [PAGE_BYTES-1:0]   rd_mask;
    logic [PIDX_W-1:0]       rd_page;
    logic                    clr;
    logic [ROW_W-1:0]        row_dist;

    pcw_store #(
        .PAGE_BYTES  (PAGE_BYTES),
        .CACHE_PAGES (CACHE_PAGES),
        .ROW_W       (ROW_W)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_valid_i (ld_valid),
        .ld_row_i   (ld_addr[ADDR_W-1:BYTE_W]),
        .ld_byte_i  (ld_addr[BYTE_W-1:0]),
        .ld_data_i  (ld_data),
        .busy_i     (busy),
        .clr_i      (clr),
        .rd_page_i  (rd_page),
        .base_row_o (base_row),
        .valid_o    (page_valid),
        .rd_data_o  (rd_data),
        .rd_mask_o  (rd_mask)
    );

    pcw_seq #(
        .PAGE_BYTES   (PAGE_BYTES),
        .CACHE_PAGES  (CACHE_PAGES),
        .ROW_W        (ROW_W),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit),
        .valid_i    (page_valid),
        .base_row_i (base_row),
        .rd_data_i  (rd_data),
        .rd_mask_i  (rd_mask),
        .rd_page_o  (rd_page),
        .clr_o      (clr),
        .busy_o     (busy),
        .start_o    (arr_start),
        .row_o      (arr_row),
        .data_o     (arr_data),
        .mask_o     (arr_mask)
    );

    assign row_dist = arr_row - base_row;

    AST_ROW_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |-> ({1'b0, row_dist} < WINDOW)); // R5

    AST_DONE_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (page_valid == '0)); // R8

endmodule

// File: tb/test_pcw_cache_ctrl.sv
module test_pcw_cache_ctrl;

    localparam int PB  = 8;
    localparam int CP  = 8;
    localparam int AP  = 16;
    localparam int WC  = 5;
    localparam int RW  = $clog2(AP);
    localparam int AW  = RW + $clog2(PB);

    typedef struct {
        int          row;
        logic [63:0] data;
        logic [7:0]  mask;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_data = '0;
    logic          commit = 1'b0;
    logic          busy;
    logic          arr_start;
    logic [RW-1:0] arr_row;
    logic [63:0]   arr_data;
    logic [7:0]    arr_mask;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    item_t sb[$];

    logic [7:0] m_data [CP][PB];
    logic [7:0] m_mask [CP];
    int         m_base;
    bit         m_any;

    always #5 clk = ~clk;

    pcw_cache_ctrl #(
        .PAGE_BYTES   (PB),
        .CACHE_PAGES  (CP),
        .ARRAY_PAGES  (AP),
        .WRITE_CYCLES (WC)
    ) i_pcw_cache_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .commit    (commit),
        .busy      (busy),
        .arr_start (arr_start),
        .arr_row   (arr_row),
        .arr_data  (arr_data),
        .arr_mask  (arr_mask)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int p = 0; p < CP; p++) begin
            m_mask[p] = '0;
            for (int b = 0; b < PB; b++) m_data[p][b] = '0;
        end
        m_any = 1'b0;
    endtask

    // refuse = 1 when the design is expected to be busy (R9)
    task automatic do_load(input int row, input int byt, input logic [7:0] d,
                           input bit refuse);
        int off;
        if (!refuse) begin
            if (!m_any) m_base = row;
            off = (row - m_base + AP) % AP;
            if (off < CP) begin
                m_data[off][byt] = d;
                m_mask[off][byt] = 1'b1;
                m_any = 1'b1;
            end
        end
        @(negedge clk);
        ld_valid = 1'b1;
        ld_addr  = AW'(row * PB + byt);
        ld_data  = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic do_commit();
        item_t it;
        bit    had = m_any;
        if (m_any) begin
            for (int p = 0; p < CP; p++) begin
                if (m_mask[p] != 0) begin
                    it.row  = (m_base + p) % AP;
                    it.mask = m_mask[p];
                    for (int b = 0; b < PB; b++) it.data[8*b +: 8] = m_data[p][b];
                    sb.push_back(it);
                end
            end
        end
        model_clear();
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        if (had) check(busy == 1'b1, "R4 busy after commit", 64'(busy), 64'd1);
        else     check(busy == 1'b0, "R4 empty commit ignored", 64'(busy), 64'd0);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor: pops expected pages and checks timing
    initial begin
        int  cyc = 0;
        int  last_start = 0;
        bit  have_prev = 1'b0;
        bit  prev_busy = 1'b0;
        item_t e;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (arr_start) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R6 unexpected page write", 64'(arr_row), 64'd0);
                    end else begin
                        e = sb.pop_front();
                        check(int'(arr_row) == e.row, "R5 row", 64'(arr_row), 64'(e.row));
                        check(arr_data == e.data, "R6 data", arr_data, e.data);
                        check(arr_mask == e.mask, "R6 mask", 64'(arr_mask), 64'(e.mask));
                    end
                    if (have_prev)
                        check(cyc - last_start == WC + 1, "R7 start spacing",
                              64'(cyc - last_start), 64'(WC + 1));
                    last_start = cyc;
                    have_prev  = 1'b1;
                end
                if (prev_busy && !busy) begin
                    check(cyc - last_start == WC + 1, "R8 busy fall",
                          64'(cyc - last_start), 64'(WC + 1));
                    have_prev = 1'b0;
                end
                prev_busy = busy;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        m_base = 0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy reset", 64'(busy), 64'd0);
        check(arr_start == 1'b0, "R1 start reset", 64'(arr_start), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: commit on an empty cache
        do_commit();
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R4 still idle", 64'(busy), 64'd0);

        // R2 R3: base page 3, skip page 5, overwrite, out-of-window on both sides
        for (int b = 0; b < PB; b++) do_load(3, b, 8'(8'h30 + b), 1'b0);
        do_load(4, 2, 8'h42, 1'b0);
        do_load(4, 2, 8'h99, 1'b0);
        do_load(6, 7, 8'h67, 1'b0);
        do_load(11, 0, 8'hB0, 1'b0);
        do_load(2, 1, 8'h21, 1'b0);
        do_commit();
        // R9: load to a pending page and a second commit while busy
        do_load(6, 0, 8'hEE, 1'b1);
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        wait_idle();

        // R5 R8: new base near the top, wraps to row 0
        do_load(14, 1, 8'hE1, 1'b0);
        do_load(15, 0, 8'hF0, 1'b0);
        do_load(0, 5, 8'h05, 1'b0);
        do_load(1, 7, 8'h17, 1'b0);
        do_load(5, 3, 8'h53, 1'b0);
        do_load(6, 3, 8'h63, 1'b0);
        do_commit();
        wait_idle();

        // R8: single page, fresh base after the cache was emptied
        do_load(9, 4, 8'h94, 1'b0);
        do_commit();
        wait_idle();

        check(sb.size() == 0, "R6 all pages written", 64'(sb.size()), 64'd0);
        check(busy == 1'b0, "R8 idle at end", 64'(busy), 64'd0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule